// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. When translation is switched on, it uses the linear address to find a page-table entry in memory. The top ten bits pick one of 1024 entries in a page directory, and the directory sits at a base held in a register. That directory entry names a page table. The next ten bits pick one of 1024 entries in that table. The entry found there gives a 20-bit frame number. The frame number is joined with the low twelve offset bits to make the physical address. When translation is switched off, the address comes straight back unchanged, and the walker makes no memory reference.

The walker keeps the usage bits of the final entry up to date. On any successful translation it marks the entry as used. On a write it also marks the entry as modified. It does this with a single memory write, and only when one of those bits actually has to change. If the present flag is clear at either level, the walk stops. The walker then reports a fault and the level that faulted, and it writes nothing.

Requests arrive through a valid/ready handshake, and only one is accepted at a time. The walker talks to memory through a port that allows one access at a time, and each access is finished by an acknowledge.

Top module: `pgwalk_top`

## Requirements
- R1: When `paging_on` is 0 at the moment a request is accepted, `rsp_paddr` equals `req_addr` and `rsp_fault` is 0. `mem_req` never rises during that request, and `rsp_valid` is high on the clock cycle right after the acceptance edge.
- R2: The first memory access is a read at `{dir_base[31:12],12'h000} + req_addr[31:22]*4`. Bits 11:0 of `dir_base` are ignored, and every memory address is a multiple of 4.
- R3: If bit 0 (present) of the directory entry is 1, the second access is a read at `{dir_entry[31:12],12'h000} + req_addr[21:12]*4`. Bits 11:0 of the directory entry take no part in this address.
- R4: If bit 0 of the page-table entry is 1, `rsp_paddr` is `{pte[31:12], req_addr[11:0]}` and `rsp_fault` is 0.
- R5: If the directory entry has bit 0 clear, the walk ends after that one read. The walker gives `rsp_fault`=1, `rsp_fault_lvl`=0 and `rsp_paddr`=0, and it does not write.
- R6: If the page-table entry has bit 0 clear, the walk ends after two reads. The walker gives `rsp_fault`=1, `rsp_fault_lvl`=1 and `rsp_paddr`=0, and it does not write.
- R7: After a successful walk, the page-table entry in memory has bit 5 (accessed) set, and all other bits are kept except bit 6. A write-back is a single write to the entry's own address. It is issued only when the new value differs from the value that was read.
- R8: Bit 6 (dirty) is set by a request with `req_write`=1. It is left as it was by a request with `req_write`=0.
- R9: `req_ready` is 1 only while the walker is idle, including straight after reset. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is a single-cycle pulse, and `req_ready` is 1 again on the cycle after it.
- R10: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` held steady until a clock edge that sees `mem_ack`=1. Each access is taken exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paging_on | input | 1 | Translation enable, sampled when a request is accepted |
| dir_base | input | 32 | Page directory base address; only bits 31:12 are used |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | The access being translated is a write |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address, or 0 on a fault |
| rsp_fault | output | 1 | Page not present |
| rsp_fault_lvl | output | 1 | Faulting level: 0 directory, 1 page table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write data (updated entry) |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |

## Verification
A bypass result is due exactly one cycle after the acceptance edge, and the bench checks that exact negedge. A walk result appears one cycle after the last memory acknowledge. The number of acknowledges depends on the memory latency, so the bench waits for the strobe rather than counting cycles. It then checks the result, the count of reads and writes, each access address, and the entry now in its memory model.

The bench model answers on falling edges with a latency that changes from one request to the next (0 to 2 extra cycles). This exercises the hold-until-acknowledge rule. The bench reads every expected value from its own copy of memory before it issues the request.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // Walk sequencer states
  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_RD_DIR  = 3'd1,
    WS_RD_PTE  = 3'd2,
    WS_WR_BACK = 3'd3,
    WS_DONE    = 3'd4
  } walk_state_e;

  // Fault level encoding
  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_TBL = 1'b1;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        paging_on,
  input  logic        mem_ack,
  input  logic        ent_present,
  input  logic        pte_need_wb,
  output walk_state_e state_q
);

  walk_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE: begin
        if (req_fire) state_d = paging_on ? WS_RD_DIR : WS_DONE;
      end
      WS_RD_DIR: begin
        if (mem_ack) state_d = ent_present ? WS_RD_PTE : WS_DONE;
      end
      WS_RD_PTE: begin
        if (mem_ack) begin
          if (ent_present && pte_need_wb) state_d = WS_WR_BACK;
          else                            state_d = WS_DONE;
        end
      end
      WS_WR_BACK: begin
        if (mem_ack) state_d = WS_DONE;
      end
      WS_DONE:  state_d = WS_IDLE;
      default:  state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pgwalk_entupd.sv
module pgwalk_entupd #(
  parameter int ENT_W     = 32,
  parameter int PRES_BIT  = 0,
  parameter int ACC_BIT   = 5,
  parameter int DIRTY_BIT = 6
) (
  input  logic [ENT_W-1:0] pte_in,
  input  logic             is_write,
  output logic             present,
  output logic [ENT_W-1:0] pte_out,
  output logic             need_wb
);

  logic [ENT_W-1:0] set_mask;

  always_comb begin
    set_mask            = '0;
    set_mask[ACC_BIT]   = 1'b1;
    set_mask[DIRTY_BIT] = is_write;
    present             = pte_in[PRES_BIT];
    pte_out             = pte_in | set_mask;
    need_wb             = (pte_out != pte_in);
  end

endmodule

// File: rtl/pgwalk_addrgen.sv
module pgwalk_addrgen
  import pgwalk_pkg::*;
#(
  parameter int DIR_W  = 10,
  parameter int TBL_W  = 10,
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 2,
  localparam int ADDR_W  = DIR_W + TBL_W + OFF_W,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  walk_state_e        state,
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [FRAME_W-1:0] dent_frame,
  input  logic [ADDR_W-1:0]  lin,
  output logic [ADDR_W-1:0]  mem_addr
);

  logic [ADDR_W-1:0] dir_ofs, tbl_ofs, dir_addr, tbl_addr;

  always_comb begin
    dir_ofs  = {{(ADDR_W-DIR_W-ENT_LG){1'b0}}, lin[ADDR_W-1 -: DIR_W], {ENT_LG{1'b0}}};
    tbl_ofs  = {{(ADDR_W-TBL_W-ENT_LG){1'b0}}, lin[OFF_W +: TBL_W], {ENT_LG{1'b0}}};
    dir_addr = {base_frame, {OFF_W{1'b0}}} + dir_ofs;
    tbl_addr = {dent_frame, {OFF_W{1'b0}}} + tbl_ofs;
    unique case (state)
      WS_RD_DIR:             mem_addr = dir_addr;
      WS_RD_PTE, WS_WR_BACK: mem_addr = tbl_addr;
      default:               mem_addr = '0;
    endcase
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int DIR_W     = 10,
  parameter int TBL_W     = 10,
  parameter int OFF_W     = 12,
  parameter int ENT_LG    = 2,
  parameter int PRES_BIT  = 0,
  parameter int ACC_BIT   = 5,
  parameter int DIRTY_BIT = 6,
  localparam int ADDR_W   = DIR_W + TBL_W + OFF_W,
  localparam int FRAME_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              paging_on,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_fault_lvl,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata
);

  walk_state_e        state_q;
  logic               req_fire;
  logic               ent_present, pte_need_wb;
  logic [ADDR_W-1:0]  pte_upd;

  logic [ADDR_W-1:0]  lin_q;
  logic               wr_q;
  logic [FRAME_W-1:0] base_q, dent_q;
  logic [ADDR_W-1:0]  pte_q;
  logic [ADDR_W-1:0]  paddr_q, paddr_d;
  logic               fault_q, fault_d, lvl_q, lvl_d;
  logic               take_en, dent_en, pte_en, res_en;

  assign req_ready = (state_q == WS_IDLE);
  assign req_fire  = req_valid && req_ready;

  pgwalk_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_fire    (req_fire),
    .paging_on   (paging_on),
    .mem_ack     (mem_ack),
    .ent_present (ent_present),
    .pte_need_wb (pte_need_wb),
    .state_q     (state_q)
  );

  pgwalk_entupd #(
    .ENT_W     (ADDR_W),
    .PRES_BIT  (PRES_BIT),
    .ACC_BIT   (ACC_BIT),
    .DIRTY_BIT (DIRTY_BIT)
  ) u_entupd (
    .pte_in   (mem_rdata),
    .is_write (wr_q),
    .present  (ent_present),
    .pte_out  (pte_upd),
    .need_wb  (pte_need_wb)
  );

  pgwalk_addrgen #(
    .DIR_W  (DIR_W),
    .TBL_W  (TBL_W),
    .OFF_W  (OFF_W),
    .ENT_LG (ENT_LG)
  ) u_addrgen (
    .state      (state_q),
    .base_frame (base_q),
    .dent_frame (dent_q),
    .lin        (lin_q),
    .mem_addr   (mem_addr)
  );

  // Datapath load enables and result selection
  always_comb begin
    take_en = req_fire;
    dent_en = (state_q == WS_RD_DIR) && mem_ack && ent_present;
    pte_en  = (state_q == WS_RD_PTE) && mem_ack;
    res_en  = 1'b0;
    paddr_d = '0;
    fault_d = 1'b0;
    lvl_d   = LVL_DIR;
    if (req_fire && !paging_on) begin
      res_en  = 1'b1;
      paddr_d = req_addr;
    end else if ((state_q == WS_RD_DIR) && mem_ack && !ent_present) begin
      res_en  = 1'b1;
      fault_d = 1'b1;
      lvl_d   = LVL_DIR;
    end else if (pte_en) begin
      res_en = 1'b1;
      if (ent_present) begin
        paddr_d = {mem_rdata[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
      end else begin
        fault_d = 1'b1;
        lvl_d   = LVL_TBL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q  <= '0;
      wr_q   <= 1'b0;
      base_q <= '0;
    end else if (take_en) begin
      lin_q  <= req_addr;
      wr_q   <= req_write;
      base_q <= dir_base[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dent_q <= '0;
    else if (dent_en) dent_q <= mem_rdata[ADDR_W-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pte_q <= '0;
    else if (pte_en) pte_q <= pte_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
      lvl_q   <= LVL_DIR;
    end else if (res_en) begin
      paddr_q <= paddr_d;
      fault_q <= fault_d;
      lvl_q   <= lvl_d;
    end
  end

  assign mem_req       = (state_q == WS_RD_DIR) || (state_q == WS_RD_PTE) ||
                         (state_q == WS_WR_BACK);
  assign mem_we        = (state_q == WS_WR_BACK);
  assign mem_wdata     = (state_q == WS_WR_BACK) ? pte_q : '0;
  assign rsp_valid     = (state_q == WS_DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = lvl_q;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int PRES_BIT = 0,
  parameter int ACC_BIT  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] lin_q
);

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_wdata)));

  assert_wb_marks_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[ACC_BIT] && mem_wdata[PRES_BIT]));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));

  assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == lin_q[OFF_W-1:0]));

endmodule

bind pgwalk_top pgwalk_chk #(
  .ADDR_W   (ADDR_W),
  .OFF_W    (OFF_W),
  .PRES_BIT (PRES_BIT),
  .ACC_BIT  (ACC_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .lin_q     (lin_q)
);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        paging_on = 1'b0;
  logic [31:0] dir_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rst_n(rst_n), .paging_on(paging_on), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model
  logic [31:0] bmem [logic [31:0]];
  int lat = 0;
  int dly = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (bmem.exists(a)) return bmem[a];
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      dly = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (dly >= lat) begin
        mem_ack = 1'b1;
        dly = 0;
        if (mem_we) bmem[mem_addr] = mem_wdata;
        else        mem_rdata = rd(mem_addr);
      end else begin
        dly++;
      end
    end
  end

  // Access monitor
  int n_rd = 0;
  int n_wr = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] wr_addr;

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (mem_we) begin
        n_wr++;
        wr_addr = mem_addr;
      end else begin
        if (n_rd < 2) rd_addr[n_rd] = mem_addr;
        n_rd++;
      end
    end
  end

  task automatic xlate(input logic [31:0] a, input bit w, input bit pg, input logic [31:0] base);
    logic [31:0] da, de, pa, pe, npe, exp_pa;
    int exp_rd, exp_wr, cyc;
    bit exp_f, exp_l;
    // expected values from the requirements
    da = {base[31:12], 12'h000} + {20'h0, a[31:22], 2'b00};
    de = rd(da);
    pa = {de[31:12], 12'h000} + {20'h0, a[21:12], 2'b00};
    pe = rd(pa);
    npe = pe | 32'h20 | (w ? 32'h40 : 32'h0);
    exp_l = 1'b0;
    if (!pg) begin
      exp_pa = a; exp_f = 0; exp_rd = 0; exp_wr = 0;
    end else if (!de[0]) begin
      exp_pa = 0; exp_f = 1; exp_l = 0; exp_rd = 1; exp_wr = 0;
    end else if (!pe[0]) begin
      exp_pa = 0; exp_f = 1; exp_l = 1; exp_rd = 2; exp_wr = 0;
    end else begin
      exp_pa = {pe[31:12], a[11:0]}; exp_f = 0; exp_rd = 2;
      exp_wr = (npe != pe) ? 1 : 0;
    end
    @(negedge clk);
    req_addr = a; req_write = w; paging_on = pg; dir_base = base; req_valid = 1'b1;
    n_rd = 0; n_wr = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    chk("R9 ready low while busy", {31'h0, req_ready}, 32'h0);
    while (!rsp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (!pg) chk("R1 bypass latency", cyc, 1);
    chk(pg ? "R4 paddr" : "R1 paddr", rsp_paddr, exp_pa);
    chk(exp_l ? "R6 fault" : "R5 fault", {31'h0, rsp_fault}, {31'h0, exp_f});
    if (exp_f) chk(exp_l ? "R6 fault level" : "R5 fault level", {31'h0, rsp_fault_lvl}, {31'h0, exp_l});
    chk("R10 read count", n_rd, exp_rd);
    chk("R7 write count", n_wr, exp_wr);
    if (exp_rd >= 1) chk("R2 directory address", rd_addr[0], da);
    if (exp_rd >= 2) chk("R3 table address", rd_addr[1], pa);
    if (exp_wr == 1) chk("R7 write-back address", wr_addr, pa);
    if (pg && de[0] && pe[0]) begin
      chk(w ? "R8 entry after write" : "R7 entry after read", rd(pa), npe);
      if (!w) chk("R8 dirty kept on read", {31'h0, rd(pa) >> 6 & 32'h1}, {31'h0, pe >> 6 & 32'h1});
    end
    @(negedge clk);
    chk("R9 ready after response", {31'h0, req_ready}, 32'h1);
  endtask

  localparam logic [31:0] BASE = 32'h0040_0ABC;
  int dl [5] = '{0, 1, 5, 600, 1023};
  int tl [5] = '{0, 1, 2, 513, 1023};
  bit done = 0;

  initial begin
    // Build the tables: directory entry 5 is left absent, 600 is not present
    foreach (dl[i]) begin
      logic [31:0] tb_addr;
      tb_addr = 32'h0100_0000 + dl[i] * 32'h1000;
      if (dl[i] != 5)
        bmem[32'h0040_0000 + dl[i] * 4] = tb_addr | 32'h0E | ((dl[i] == 600) ? 32'h0 : 32'h1);
      foreach (tl[j]) begin
        logic [31:0] fr, fl;
        fr = ((dl[i] * 37 + tl[j] * 3 + 5) & 32'hFFFFF) << 12;
        fl = (tl[j] == 2) ? 32'h0 : 32'h1;
        if (tl[j] == 1)   fl |= 32'h20;
        if (tl[j] == 513) fl |= 32'h60;
        if (tl[j] == 1023) fl |= 32'h40;
        bmem[tb_addr + tl[j] * 4] = fr | fl | 32'h180;
      end
    end
    repeat (3) @(negedge clk);
    chk("R9 reset ready", {31'h0, req_ready}, 32'h1);
    chk("R9 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R10 reset mem_req", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: bypass sweep
    for (int k = 0; k < 8; k++) begin
      lat = k % 3;
      xlate(32'h9E37_79B9 * (k + 1), k[0], 1'b0, BASE);
    end
    // Walk sweep: read, write, write again for each (dir, table) pair
    foreach (dl[i]) begin
      foreach (tl[j]) begin
        for (int r = 0; r < 3; r++) begin
          logic [31:0] la;
          lat = (i + j + r) % 3;
          la = {dl[i][9:0], tl[j][9:0], 12'(tl[j] * 7 + dl[i] * 13 + r)};
          xlate(la, r != 0, 1'b1, BASE);
        end
      end
    end
    // Bypass again after walks
    lat = 1;
    xlate(32'hFFFF_FFFF, 1'b1, 1'b0, BASE);
    xlate(32'h0000_0000, 1'b0, 1'b0, BASE);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule